// File: doc/BRIEF.md
# Six-Channel Filtered Fault Diagnostic Register

This block collects raw protection comparator outputs from six low-side power channels. It qualifies each one against the channel's on/off state and debounces it over a programmable number of system-clock cycles. The surviving fault is latched as a 2-bit code per channel. A serial interface block reads the resulting 16-bit diagnostic word. When that block issues a clear request, the word present just before the clear is frozen into a snapshot register, and the stored faults return to the healthy code. A fault detected at the very edge of the clear is kept.

Besides the six codes, the word carries two active-low summary flags. One is a latched over-temperature flag, set by any thermal sensor of a switched-on channel. The other is a common fault flag, low whenever any channel holds a fault code. The word is a plain status vector and the clear request is a single-cycle control pulse. No interface on this block carries a data stream, so there is no valid/ready handshake and no back-pressure. The word is always valid and the snapshot is valid from the cycle after a clear.

Top module: `diag_fault_reg`

## Requirements
- R1: While `rst_n` is low and after its release, `diag_word` and `snap_word` read 16'hFFFF until an input changes them.
- R2: Word layout: bits [15:14] are constant 1. Bit 13 is the fault flag and bit 12 the over-temperature flag. Channel i (0..5) occupies bits [2i+1:2i]. Codes are 2'b11 for healthy, 2'b10 for overload or over-temperature, 2'b01 for open load and 2'b00 for short to ground.
- R3: Overload and over-temperature inputs have no effect while the channel is off. Short-to-ground and open-load inputs have no effect while it is on.
- R4: Overload, short-to-ground and open-load codes are stored only at the clock edge that samples the same qualified condition for the FILT_CYC-th consecutive time. The count restarts when the condition disappears, changes kind, or the on/off state changes.
- R5: Over-temperature on a switched-on channel stores 2'b10 at the first edge that samples it, without filtering, and drives bit 12 low.
- R6: A newly filtered fault overwrites a previously stored different fault code on the same channel.
- R7: When short-to-ground and open load are both present on an off channel, the qualified condition is short to ground (2'b00).
- R8: A stored fault code stays in place after its cause disappears and changes to 2'b11 only through a clear request or reset.
- R9: A `clr_req` sampled high returns all codes to 2'b11 and bit 12 to 1. The exception is a channel storing a fault, or an over-temperature being sampled, at that same edge.
- R10: At an edge that samples `clr_req` high, `snap_word` takes the `diag_word` value from before the edge. It holds its value otherwise.
- R11: Bit 13 is 0 in the same cycle that any channel code differs from 2'b11, and 1 otherwise.
- R12: Bit 12 stays 0 after the thermal input drops, until a clear request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_on | input | 6 | Current on (1) / off (0) state of each channel |
| ovl_raw | input | 6 | Raw overload / short-to-battery comparator per channel |
| scg_raw | input | 6 | Raw short-to-ground comparator per channel |
| opn_raw | input | 6 | Raw open-load comparator per channel |
| ot_raw | input | 6 | Raw thermal sensor per channel |
| clr_req | input | 1 | Single-cycle clear request from the serial block |
| diag_word | output | 16 | Live diagnostic word |
| snap_word | output | 16 | Word captured at the last clear |

## Verification
The bench targets the filter boundary. It holds a fault for one cycle short of the filter time, and it switches the condition kind before the count completes. A design with an off-by-one counter, or one that fails to restart, would store a code a cycle early or combine two partial runs into one. It drives comparators against the wrong on/off state, and applies short-to-ground together with open load, to expose missing qualification or a wrong priority. It issues a clear while an open load persists and checks the snapshot, so that a design letting the clear win over a same-edge detection, or capturing the post-clear word, shows a wrong code or snapshot.

// File: rtl/diag_pkg.sv
package diag_pkg;

  typedef logic [1:0] dcode_t;

  localparam dcode_t CODE_OK   = 2'b11;
  localparam dcode_t CODE_HI   = 2'b10;  // overload / over-temperature
  localparam dcode_t CODE_OPEN = 2'b01;
  localparam dcode_t CODE_GND  = 2'b00;

  typedef struct packed {
    logic   hit;
    dcode_t code;
  } cond_t;

endpackage

// File: rtl/diag_cond_sel.sv
module diag_cond_sel
  import diag_pkg::*;
(
  input  logic  on_i,
  input  logic  ovl_i,
  input  logic  scg_i,
  input  logic  opn_i,
  output cond_t cond_o
);

  // State-dependent qualification; ground short outranks open load.
  always_comb begin
    cond_o = '{hit: 1'b0, code: CODE_OK};
    if (on_i) begin
      if (ovl_i) cond_o = '{hit: 1'b1, code: CODE_HI};
    end else if (scg_i) begin
      cond_o = '{hit: 1'b1, code: CODE_GND};
    end else if (opn_i) begin
      cond_o = '{hit: 1'b1, code: CODE_OPEN};
    end
  end

endmodule

// File: rtl/diag_chan_filter.sv
module diag_chan_filter
  import diag_pkg::*;
#(
  parameter int FILT_CYC = 30000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  cond_t  cond_i,
  input  logic   ot_now_i,
  input  logic   clr_i,
  output dcode_t code_o
);

  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] FILT_W = CW'(FILT_CYC);

  cond_t          prev_q;
  logic [CW-1:0]  run_q, run_nxt;
  logic           same, store;
  dcode_t         code_q;

  assign same = cond_i.hit && prev_q.hit && (cond_i.code == prev_q.code);

  always_comb begin
    if (!cond_i.hit)       run_nxt = '0;
    else if (!same)        run_nxt = CW'(1);
    else if (run_q >= FILT_W) run_nxt = run_q;
    else                   run_nxt = run_q + CW'(1);
  end

  assign store = cond_i.hit && (run_nxt >= FILT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '{hit: 1'b0, code: CODE_OK};
      run_q  <= '0;
      code_q <= CODE_OK;
    end else begin
      prev_q <= cond_i;
      run_q  <= run_nxt;
      if (store)         code_q <= cond_i.code;
      else if (ot_now_i) code_q <= CODE_HI;
      else if (clr_i)    code_q <= CODE_OK;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/diag_fault_reg.sv
module diag_fault_reg
  import diag_pkg::*;
#(
  parameter int NCH      = 6,
  parameter int FILT_CYC = 30000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     ch_on,
  input  logic [NCH-1:0]     ovl_raw,
  input  logic [NCH-1:0]     scg_raw,
  input  logic [NCH-1:0]     opn_raw,
  input  logic [NCH-1:0]     ot_raw,
  input  logic               clr_req,
  output logic [2*NCH+3:0]   diag_word,
  output logic [2*NCH+3:0]   snap_word
);

  localparam int WW = 2*NCH + 4;

  logic [2*NCH-1:0] code_vec;
  logic [NCH-1:0]   ot_hit;
  logic             ot_lat_n;
  logic             fault_n;
  logic [WW-1:0]    word_now;
  logic [WW-1:0]    snap_q;

  assign ot_hit = ch_on & ot_raw;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cond_t  cond;
    dcode_t code;

    diag_cond_sel u_sel (
      .on_i   (ch_on[g]),
      .ovl_i  (ovl_raw[g]),
      .scg_i  (scg_raw[g]),
      .opn_i  (opn_raw[g]),
      .cond_o (cond)
    );

    diag_chan_filter #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond_i   (cond),
      .ot_now_i (ot_hit[g]),
      .clr_i    (clr_req),
      .code_o   (code)
    );

    assign code_vec[2*g +: 2] = code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ot_lat_n <= 1'b1;
    else if (|ot_hit) ot_lat_n <= 1'b0;
    else if (clr_req) ot_lat_n <= 1'b1;
  end

  assign fault_n  = &code_vec;
  assign word_now = {2'b11, fault_n, ot_lat_n, code_vec};

  always_ff @(posedge clk) begin
    if (!rst_n)       snap_q <= '1;
    else if (clr_req) snap_q <= word_now;
  end

  assign diag_word = word_now;
  assign snap_word = snap_q;

endmodule

// File: rtl/diag_fault_reg_chk.sv
module diag_fault_reg_chk #(
  parameter int NCH = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   ch_on,
  input logic [NCH-1:0]   ot_raw,
  input logic             clr_req,
  input logic [2*NCH+3:0] diag_word,
  input logic [2*NCH+3:0] snap_word
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_keep_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_word[2*g +: 2] != 2'b11) |=>
        ((diag_word[2*g +: 2] != 2'b11) || $past(clr_req)));

    p_hi_when_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_word[2*g +: 2] != 2'b10) |=>
        ((diag_word[2*g +: 2] != 2'b10) || $past(ch_on[g])));

    p_gnd_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_word[2*g +: 2] != 2'b00) |=>
        ((diag_word[2*g +: 2] != 2'b00) || !$past(ch_on[g])));

    p_open_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_word[2*g +: 2] != 2'b01) |=>
        ((diag_word[2*g +: 2] != 2'b01) || !$past(ch_on[g])));
  end

  p_ot_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_on & ot_raw)) |=> !diag_word[2*NCH]);

  p_ot_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_word[2*NCH] |=> (!diag_word[2*NCH] || $past(clr_req)));

  p_snap_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (snap_word == $past(diag_word)));

  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> $stable(snap_word));

endmodule

bind diag_fault_reg diag_fault_reg_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_on     (ch_on),
  .ot_raw    (ot_raw),
  .clr_req   (clr_req),
  .diag_word (diag_word),
  .snap_word (snap_word)
);

// File: tb/diag_fault_reg_test.sv
module diag_fault_reg_test;

  localparam int NCH  = 6;
  localparam int FILT = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic           rst_n;
  logic [NCH-1:0] on, ovl, scg, opn, ot;
  logic           clr;
  logic [15:0]    word, snap;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  diag_fault_reg #(.NCH(NCH), .FILT_CYC(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .ch_on(on), .ovl_raw(ovl), .scg_raw(scg),
    .opn_raw(opn), .ot_raw(ot), .clr_req(clr), .diag_word(word), .snap_word(snap)
  );

  // ---------------- behavioural reference ----------------
  logic [1:0]  m_code [NCH];
  int          m_run  [NCH];
  int          m_prev [NCH];
  logic        m_ot;
  logic [15:0] m_snap;
  logic [15:0] w_old;

  function automatic logic [15:0] m_word();
    logic [15:0] w;
    bit any_fault = 0;
    w = 16'hFFFF;
    for (int i = 0; i < NCH; i++) begin
      w[2*i +: 2] = m_code[i];
      if (m_code[i] != 2'b11) any_fault = 1;
    end
    w[13] = !any_fault;
    w[12] = m_ot;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_code[i] = 2'b11; m_run[i] = 0; m_prev[i] = -1;
      end
      m_ot = 1'b1; m_snap = 16'hFFFF;
    end else begin
      w_old = m_word();
      for (int i = 0; i < NCH; i++) begin
        int c;
        c = -1;
        if (on[i]) begin
          if (ovl[i]) c = 2;
        end else if (scg[i]) c = 0;
        else if (opn[i]) c = 1;
        if (c < 0) m_run[i] = 0;
        else if (c == m_prev[i]) m_run[i] = (m_run[i] < FILT) ? m_run[i] + 1 : m_run[i];
        else m_run[i] = 1;
        m_prev[i] = c;
        if (c >= 0 && m_run[i] >= FILT) m_code[i] = 2'(c);
        else if (on[i] && ot[i])        m_code[i] = 2'b10;
        else if (clr)                   m_code[i] = 2'b11;
      end
      if (|(on & ot)) m_ot = 1'b0;
      else if (clr)   m_ot = 1'b1;
      if (clr) m_snap = w_old;
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic [15:0] e;
      e = m_word();
      chk("R2/R4/R6 channel codes", {4'h0, word[11:0]}, {4'h0, e[11:0]});
      chk("R2 constant top bits", {14'h0, word[15:14]}, 16'h3);
      chk("R11 fault flag", {15'h0, word[13]}, {15'h0, e[13]});
      chk("R12 over-temperature flag", {15'h0, word[12]}, {15'h0, e[12]});
      chk("R10 snapshot", snap, m_snap);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; on = '0; ovl = '0; scg = '0; opn = '0; ot = '0; clr = 0;
    step(3);
    chk("R1 reset word", word, 16'hFFFF);
    chk("R1 reset snapshot", snap, 16'hFFFF);
    rst_n = 1;
    step(1);
    chk("R1 word after release", word, 16'hFFFF);

    // R4: one cycle short, then full filter time
    on = 6'b010101;
    ovl[0] = 1; step(7);
    chk("R4 short pulse not stored", {14'h0, word[1:0]}, 16'h3);
    ovl[0] = 0; step(1);
    ovl[0] = 1; step(8);
    chk("R4 stored after filter", {14'h0, word[1:0]}, 16'h2);
    ovl[0] = 0;

    // R3: comparators against the wrong state
    ovl[1] = 1; ot[1] = 1; scg[2] = 1; opn[2] = 1;
    step(20);
    chk("R3 off overload ignored", {14'h0, word[3:2]}, 16'h3);
    chk("R3 on ground/open ignored", {14'h0, word[5:4]}, 16'h3);
    chk("R3 off thermal ignored", {15'h0, word[12]}, 16'h1);
    ovl[1] = 0; ot[1] = 0; scg[2] = 0; opn[2] = 0;

    // R7: ground short wins over open load
    scg[3] = 1; opn[3] = 1; step(8);
    chk("R7 ground priority", {14'h0, word[7:6]}, 16'h0);
    // R6 and R4 restart on change of kind
    scg[3] = 0; step(7);
    chk("R4 restart on kind change", {14'h0, word[7:6]}, 16'h0);
    step(1);
    chk("R6 last fault wins", {14'h0, word[7:6]}, 16'h1);
    opn[3] = 0;

    // R8: faults persist after cause vanishes
    step(10);
    chk("R8 channel 3 kept", {14'h0, word[7:6]}, 16'h1);
    chk("R8 channel 0 kept", {14'h0, word[1:0]}, 16'h2);
    chk("R11 fault flag low", {15'h0, word[13]}, 16'h0);

    // R5 / R12: unfiltered thermal
    ot[4] = 1; step(1);
    chk("R5 thermal immediate", {14'h0, word[9:8]}, 16'h2);
    chk("R5 thermal flag", {15'h0, word[12]}, 16'h0);
    ot[4] = 0; step(5);
    chk("R12 thermal flag latched", {15'h0, word[12]}, 16'h0);

    // R9 / R10: clear with a persisting open load on channel 5
    opn[5] = 1; step(10);
    chk("R2 word before clear", word, 16'hC67E);
    clr = 1; step(1); clr = 0;
    chk("R9 clear keeps same-edge fault", word, 16'hD7FF);
    chk("R10 snapshot of pre-clear word", snap, 16'hC67E);
    opn[5] = 0; step(1);
    clr = 1; step(1); clr = 0;
    chk("R9 full clear", word, 16'hFFFF);
    chk("R10 second snapshot", snap, 16'hD7FF);

    // randomized phase, compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NCH; i++) begin
        if ($urandom % 8 == 0) {on[i], ovl[i], scg[i], opn[i]} = 4'($urandom);
        ot[i] = ($urandom % 97 == 0);
      end
      clr = ($urandom % 40 == 0);
      step(1);
    end
    clr = 0;
    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule